// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block decides which interrupt a 16550-style serial port reports and drives its interrupt request line. It watches five sources: received data reaching a programmable fill threshold, a character-timeout strobe, line error or break events, the transmit holding register turning empty, and modem status changes. Each source can be masked by its own enable bit. The highest-priority cause that is both pending and enabled is encoded as a fixed 4-bit code in the identification byte. The upper two bits of that byte show whether the FIFOs are on.

Event-style sources are held in sticky pending flags. Each flag is cleared by the register access that services it. The received-data cause is a live comparison of the receive fill level against the trigger threshold, so it drops as soon as the level falls below it. The request output follows the presence of any reported cause, and it is gated by an output-enable bit from the modem control register. The block has no data stream. All of its pins are plain control and status signals that are sampled on the rising clock edge.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, with the FIFOs disabled, `iid` reads 0x01 and `irq` is low.
- R2: The cause codes in `iid[3:0]` are 0001 for none, 0110 for line status, 0100 for received data, 1100 for character timeout, 0010 for transmitter empty and 0000 for modem status. The enable bits are `ier[0]` for received data and timeout, `ier[1]` for transmitter empty, `ier[2]` for line status and `ier[3]` for modem status.
- R3: When several causes are pending, only the highest-priority enabled one is reported. The order from highest to lowest is line status, received data, timeout, transmitter empty, modem status.
- R4: A `line_evt` pulse makes the line cause pending from the next cycle. An `lsr_rd` pulse clears it, but a new event in the same cycle wins.
- R5: Received data is reported while `rx_level` is at or above the threshold. With the FIFOs enabled, `rx_trig` 00, 01, 10 and 11 give thresholds of 1, 4, 8 and 14. The cause drops in the cycle the level falls below the threshold.
- R6: With the FIFOs enabled, a `rx_timeout` pulse makes the timeout cause pending, and an `rbr_rd` pulse clears it. With the FIFOs disabled, timeout is never reported and the threshold is 1 byte whatever `rx_trig` holds.
- R7: A rising edge of `thr_empty` makes the transmitter-empty cause pending. It is cleared by a `thr_wr` pulse, or by an `iid_rd` pulse while 0010 is the reported code. A clear wins over a set in the same cycle.
- R8: A `msr_change` pulse makes the modem cause pending, and an `msr_rd` pulse clears it.
- R9: `iid[7:6]` reads 11 when `fifo_en` is high and 00 when it is low. `iid[5:4]` always reads 00.
- R10: `irq` is high exactly when `out_en` is high and `iid[3:0]` is not 0001.
- R11: A masked cause stays pending. It is reported as soon as its enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier | input | 4 | Interrupt enable bits |
| fifo_en | input | 1 | FIFOs enabled |
| rx_trig | input | 2 | Receive trigger select |
| rx_level | input | LVL_W | Receive FIFO fill level |
| line_evt | input | 1 | Line error or break event pulse |
| rx_timeout | input | 1 | Character-timeout strobe |
| thr_empty | input | 1 | Transmit holding register empty |
| thr_wr | input | 1 | Transmit holding register write pulse |
| msr_change | input | 1 | Modem status change pulse |
| lsr_rd | input | 1 | Line status register read pulse |
| rbr_rd | input | 1 | Receive buffer read pulse |
| msr_rd | input | 1 | Modem status register read pulse |
| iid_rd | input | 1 | Identification register read pulse |
| out_en | input | 1 | Interrupt output enable |
| iid | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is one where several causes are pending at once and one of them is masked. The stimulus builds this state up in layers. It holds the fill level above a threshold while it pulses a line event. It leaves a modem change pending with its enable cleared, then enables it. It brings a fresh transmitter-empty edge in on top of that pending modem cause. At each layer, the reported code must step down through the priority order as each cause is serviced. A bench model tracks the pending flags independently and compares `iid` and `irq` on every clock.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;
  typedef enum logic [3:0] {
    CAUSE_MODEM   = 4'b0000,
    CAUSE_NONE    = 4'b0001,
    CAUSE_THRE    = 4'b0010,
    CAUSE_RXDATA  = 4'b0100,
    CAUSE_LINE    = 4'b0110,
    CAUSE_TIMEOUT = 4'b1100
  } cause_e;

  typedef struct packed {
    logic line;
    logic rxdata;
    logic timeout;
    logic thre;
    logic modem;
  } cause_vec_t;

  localparam int NUM_STICKY = 4;
endpackage

// File: rtl/iid_rx_thresh.sv
module iid_rx_thresh #(
  parameter int LVL_W = 5
) (
  input  logic             fifo_en,
  input  logic [1:0]       rx_trig,
  input  logic [LVL_W-1:0] rx_level,
  output logic             rx_avail
);
  logic [LVL_W-1:0] thresh;

  always_comb begin
    thresh = LVL_W'(1);
    if (fifo_en) begin
      case (rx_trig)
        2'b00:   thresh = LVL_W'(1);
        2'b01:   thresh = LVL_W'(4);
        2'b10:   thresh = LVL_W'(8);
        default: thresh = LVL_W'(14);
      endcase
    end
  end

  assign rx_avail = (rx_level >= thresh);
endmodule

// File: rtl/iid_sticky.sv
module iid_sticky #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pend_o <= 1'b0;
    else if (SET_WINS) begin
      if (set_i)              pend_o <= 1'b1;
      else if (clr_i)         pend_o <= 1'b0;
    end else begin
      if (clr_i)              pend_o <= 1'b0;
      else if (set_i)         pend_o <= 1'b1;
    end
  end
endmodule

// File: rtl/iid_prio_enc.sv
module iid_prio_enc
  import uart_iid_pkg::*;
(
  input  cause_vec_t req,
  input  logic [3:0] ier,
  input  logic       fifo_en,
  output cause_e     cause
);
  always_comb begin
    if (req.line && ier[2])                    cause = CAUSE_LINE;
    else if (req.rxdata && ier[0])             cause = CAUSE_RXDATA;
    else if (req.timeout && fifo_en && ier[0]) cause = CAUSE_TIMEOUT;
    else if (req.thre && ier[1])               cause = CAUSE_THRE;
    else if (req.modem && ier[3])              cause = CAUSE_MODEM;
    else                                       cause = CAUSE_NONE;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_iid_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       ier,
  input  logic             fifo_en,
  input  logic [1:0]       rx_trig,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             line_evt,
  input  logic             rx_timeout,
  input  logic             thr_empty,
  input  logic             thr_wr,
  input  logic             msr_change,
  input  logic             lsr_rd,
  input  logic             rbr_rd,
  input  logic             msr_rd,
  input  logic             iid_rd,
  input  logic             out_en,
  output logic [7:0]       iid,
  output logic             irq
);
  localparam int LINE_I = 0, TMO_I = 1, THRE_I = 2, MDM_I = 3;

  cause_e     cause;
  cause_vec_t req;
  logic       rx_avail;
  logic       te_q;
  logic [NUM_STICKY-1:0] s_set, s_clr, s_pend;
  localparam logic [NUM_STICKY-1:0] WIN_MASK = 4'b1011;

  iid_rx_thresh #(.LVL_W(LVL_W)) u_thresh (
    .fifo_en (fifo_en),
    .rx_trig (rx_trig),
    .rx_level(rx_level),
    .rx_avail(rx_avail)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) te_q <= 1'b1;
    else        te_q <= thr_empty;
  end

  always_comb begin
    s_set[LINE_I] = line_evt;
    s_clr[LINE_I] = lsr_rd;
    s_set[TMO_I]  = rx_timeout && fifo_en;
    s_clr[TMO_I]  = rbr_rd || !fifo_en;
    s_set[THRE_I] = thr_empty && !te_q;
    s_clr[THRE_I] = thr_wr || (iid_rd && cause == CAUSE_THRE);
    s_set[MDM_I]  = msr_change;
    s_clr[MDM_I]  = msr_rd;
  end

  for (genvar g = 0; g < NUM_STICKY; g++) begin : g_sticky
    iid_sticky #(.SET_WINS(WIN_MASK[g])) u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (s_set[g]),
      .clr_i (s_clr[g]),
      .pend_o(s_pend[g])
    );
  end

  always_comb begin
    req.line    = s_pend[LINE_I];
    req.rxdata  = rx_avail;
    req.timeout = s_pend[TMO_I];
    req.thre    = s_pend[THRE_I];
    req.modem   = s_pend[MDM_I];
  end

  iid_prio_enc u_prio (
    .req    (req),
    .ier    (ier),
    .fifo_en(fifo_en),
    .cause  (cause)
  );

  assign iid = {{2{fifo_en}}, 2'b00, cause};
  assign irq = out_en && (cause != CAUSE_NONE);
endmodule

// File: rtl/uart_iid_chk.sv
module uart_iid_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] ier,
  input logic       fifo_en,
  input logic       line_evt,
  input logic       thr_wr,
  input logic       out_en,
  input logic [7:0] iid,
  input logic       irq
);
  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !irq);
  // R10
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && iid[3:0] != 4'b0001) |-> irq);
  // R9
  fifo_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iid[7:4] == {fifo_en, fifo_en, 2'b00});
  // R4
  line_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_evt && ier[2]) |=> (!ier[2] || iid[3:0] == 4'b0110));
  // R6
  no_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> iid[3:0] != 4'b1100);
  // R7
  thre_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> iid[3:0] != 4'b0010);
  // R2
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iid[3:0] inside {4'b0000, 4'b0001, 4'b0010, 4'b0100, 4'b0110, 4'b1100});
endmodule

bind uart_irq_ident uart_iid_chk u_chk (.*);

// File: tb/tb_uart_irq_ident.sv
`timescale 1ns/1ps
module tb_uart_irq_ident;
  localparam int LVL_W = 5;
  logic clk = 0, rst_n = 0;
  logic [3:0] ier = 0;
  logic fifo_en = 0, line_evt = 0, rx_timeout = 0, thr_empty = 0, thr_wr = 0;
  logic msr_change = 0, lsr_rd = 0, rbr_rd = 0, msr_rd = 0, iid_rd = 0, out_en = 1;
  logic [1:0] rx_trig = 0;
  logic [LVL_W-1:0] rx_level = 0;
  logic [7:0] iid;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_irq_ident dut (.*);

  // behavioural reference state
  bit m_line, m_to, m_thre, m_msr, m_te;

  function automatic logic [3:0] mcode();
    int th;
    th = !fifo_en ? 1 : (rx_trig == 0 ? 1 : rx_trig == 1 ? 4 : rx_trig == 2 ? 8 : 14);
    if (m_line && ier[2]) return 4'b0110;
    if (int'(rx_level) >= th && ier[0]) return 4'b0100;
    if (m_to && fifo_en && ier[0]) return 4'b1100;
    if (m_thre && ier[1]) return 4'b0010;
    if (m_msr && ier[3]) return 4'b0000;
    return 4'b0001;
  endfunction

  task automatic chk(string req, logic [7:0] ei, logic eq);
    checks++;
    if (iid !== ei || irq !== eq) begin
      errors++;
      $display("FAIL %s: iid=%h irq=%b expected iid=%h irq=%b", req, iid, irq, ei, eq);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_line = 0; m_to = 0; m_thre = 0; m_msr = 0; m_te = 1;
    end else begin
      logic [3:0] c;
      c = mcode();
      if (line_evt) m_line = 1; else if (lsr_rd) m_line = 0;
      if (rx_timeout && fifo_en) m_to = 1; else if (rbr_rd || !fifo_en) m_to = 0;
      if (thr_wr || (iid_rd && c == 4'b0010)) m_thre = 0;
      else if (thr_empty && !m_te) m_thre = 1;
      if (msr_change) m_msr = 1; else if (msr_rd) m_msr = 0;
      m_te = thr_empty;
      #3;
      checks++;
      if (iid[3:0] !== mcode()) begin errors++;
        $display("FAIL R3: model code %b, iid[3:0]=%b", mcode(), iid[3:0]); end
      checks++;
      if (iid[7:4] !== {fifo_en, fifo_en, 2'b00}) begin errors++;
        $display("FAIL R9: iid[7:4]=%b expected %b", iid[7:4], {fifo_en, fifo_en, 2'b00}); end
      checks++;
      if (irq !== (out_en && mcode() != 4'b0001)) begin errors++;
        $display("FAIL R10: irq=%b expected %b", irq, out_en && mcode() != 4'b0001); end
    end
  end

  task automatic settle(); @(posedge clk); #3; endtask
  task automatic nxt(); @(negedge clk); endtask

  initial begin
    repeat (3) nxt();
    rst_n = 1;
    settle(); chk("R1 reset", 8'h01, 0);
    nxt(); fifo_en = 1; rx_trig = 2'b01; settle(); chk("R9 fifo on", 8'hC1, 0);
    nxt(); ier = 4'b1111; rx_level = 3; settle(); chk("R5 below 4", 8'hC1, 0);
    nxt(); rx_level = 4; settle(); chk("R5 trig 4", 8'hC4, 1);
    nxt(); ier = 4'b1110; settle(); chk("R2 rx masked", 8'hC1, 0);
    nxt(); ier = 4'b1111; rx_trig = 2'b11; rx_level = 13; settle(); chk("R5 below 14", 8'hC1, 0);
    nxt(); rx_level = 14; settle(); chk("R5 trig 14", 8'hC4, 1);
    nxt(); line_evt = 1; nxt(); line_evt = 0; settle(); chk("R3 line over rx", 8'hC6, 1);
    nxt(); lsr_rd = 1; nxt(); lsr_rd = 0; settle(); chk("R4 lsr read", 8'hC4, 1);
    nxt(); rx_trig = 2'b10; rx_level = 8; settle(); chk("R5 trig 8", 8'hC4, 1);
    nxt(); rx_level = 7; settle(); chk("R5 drops below 8", 8'hC1, 0);
    nxt(); rx_trig = 2'b00; rx_level = 1; settle(); chk("R5 trig 1", 8'hC4, 1);
    nxt(); rx_level = 0; rx_timeout = 1; nxt(); rx_timeout = 0; settle(); chk("R6 timeout", 8'hCC, 1);
    nxt(); rbr_rd = 1; nxt(); rbr_rd = 0; settle(); chk("R6 rbr read", 8'hC1, 0);
    nxt(); fifo_en = 0; rx_timeout = 1; nxt(); rx_timeout = 0; settle(); chk("R6 no timeout off", 8'h01, 0);
    nxt(); rx_trig = 2'b11; rx_level = 1; settle(); chk("R6 thresh 1 off", 8'h04, 1);
    nxt(); rx_level = 0; thr_empty = 1; settle(); chk("R7 thre", 8'h02, 1);
    nxt(); iid_rd = 1; nxt(); iid_rd = 0; settle(); chk("R7 iid read", 8'h01, 0);
    nxt(); thr_empty = 0; nxt(); thr_empty = 1; settle(); chk("R7 thre again", 8'h02, 1);
    nxt(); thr_wr = 1; nxt(); thr_wr = 0; settle(); chk("R7 thr write", 8'h01, 0);
    nxt(); msr_change = 1; nxt(); msr_change = 0; settle(); chk("R8 modem", 8'h00, 1);
    nxt(); out_en = 0; settle(); chk("R10 gated", 8'h00, 0);
    nxt(); out_en = 1; msr_rd = 1; nxt(); msr_rd = 0; settle(); chk("R8 msr read", 8'h01, 0);
    nxt(); ier = 4'b0000; msr_change = 1; nxt(); msr_change = 0; settle(); chk("R11 masked", 8'h01, 0);
    nxt(); ier = 4'b1000; settle(); chk("R11 unmasked", 8'h00, 1);
    nxt(); ier = 4'b1010; thr_empty = 0; nxt(); thr_empty = 1; settle(); chk("R3 thre over modem", 8'h02, 1);
    nxt(); thr_wr = 1; nxt(); thr_wr = 0; settle(); chk("R3 modem next", 8'h00, 1);
    nxt(); msr_rd = 1; nxt(); msr_rd = 0; settle(); chk("R8 cleared", 8'h01, 0);
    repeat (4) nxt();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule